// File: doc/BRIEF.md
# Immediate-Amount Barrel Shifter with Carry-Out

This block forms the second operand of a data-processing operation, or the scaled offset of a load/store address. Its inputs are a data word, a two-bit shift kind and a five-bit constant amount. It returns the shifted word, the carry produced by the shift, and a strobe that says whether that carry should be written to the carry flag. The block is purely combinational, so the result settles in the same cycle as its inputs.

An amount of zero does not always mean "no shift". For a logical right shift and an arithmetic right shift, zero stands for a shift by the full word width. For a rotate, zero selects a one-place rotate through the incoming carry. When a shift does move bits, the carry-out is the last bit shifted out of the word.

When the flag-update enable is low, which is always the case for address offsets, the carry output repeats the incoming carry and the strobe stays low. The shifted word is the same whether the enable is high or low.

Top module: `bshift_imm`

## Requirements
- R1: For kind 0 (left shift) with amount n in 1..31, result = operand << n and the shift carry = operand[32-n].
- R2: For kind 0 with amount 0, result = operand and the shift carry = carry_in.
- R3: For kind 1 (logical right) with amount n in 1..31, result = operand >> n with zero fill and the shift carry = operand[n-1].
- R4: For kind 1 with amount 0 (a shift by 32), result = 0 and the shift carry = operand[31].
- R5: For kind 2 (arithmetic right) with amount n in 1..31, result = operand >> n with operand[31] filling the vacated bits, and the shift carry = operand[n-1].
- R6: For kind 2 with amount 0 (a shift by 32), every result bit equals operand[31] and the shift carry = operand[31].
- R7: For kind 3 (rotate right) with amount n in 1..31, result = operand rotated right by n and the shift carry = operand[n-1].
- R8: For kind 3 with amount 0 (rotate through carry), result = {carry_in, operand[31:1]} and the shift carry = operand[0].
- R9: With flag_en = 0, carry_out = carry_in and carry_wr = 0 for every kind and amount, and the result is the same as with flag_en = 1.
- R10: With flag_en = 1, carry_wr = 1 and carry_out is the shift carry defined in R1 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 32 | Data word to shift |
| shift_kind | input | 2 | 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| shift_amt | input | 5 | Constant shift amount; zero has a meaning that depends on the kind |
| carry_in | input | 1 | Current carry flag |
| flag_en | input | 1 | The operation updates the flags |
| result | output | 32 | Shifted word |
| carry_out | output | 1 | New carry value |
| carry_wr | output | 1 | Strobe: write carry_out to the carry flag |

## Verification
Two functions can act in the same evaluation: the rotate-through-carry path reads carry_in into the result, and the flag path reads carry_in to produce carry_out. A zero-amount rotate with flag_en both high and low, and with carry_in of both values, makes carry_in drive result bit 31 while carry_out either takes operand bit 0 or echoes carry_in. Every kind and every amount 0..31 is swept over directed and random operands with both carry_in and flag_en values. The result, carry_out and carry_wr are each compared against a reference model in the bench.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

   typedef enum logic [1:0] {
      SK_LSL = 2'd0,
      SK_LSR = 2'd1,
      SK_ASR = 2'd2,
      SK_ROR = 2'd3
   } shift_kind_e;

endpackage

// File: rtl/bshift_funnel.sv
// Takes the low W bits of {hi, lo} shifted right by amt (amt < W).
module bshift_funnel #(
   parameter int W          = 32,
   parameter bit LOG_STAGES = 1'b1,
   localparam int AW        = $clog2(W)
) (
   input  logic [W-1:0]  hi,
   input  logic [W-1:0]  lo,
   input  logic [AW-1:0] amt,
   output logic [W-1:0]  dout
);

   localparam int DW = 2 * W;

   generate
      if (LOG_STAGES) begin : g_log
         logic [DW-1:0] stage [AW+1];
         assign stage[0] = {hi, lo};
         for (genvar k = 0; k < AW; k++) begin : g_stage
            assign stage[k+1] = amt[k] ? (stage[k] >> (1 << k)) : stage[k];
         end
         assign dout = stage[AW][W-1:0];
      end else begin : g_flat
         logic [DW-1:0] joined;
         assign joined = {hi, lo} >> amt;
         assign dout   = joined[W-1:0];
      end
   endgenerate

endmodule

// File: rtl/bshift_carry.sv
// Picks the bit that leaves the word last, with zero-amount special cases.
module bshift_carry
   import bshift_pkg::*;
#(
   parameter int W  = 32,
   localparam int AW = $clog2(W)
) (
   input  logic [W-1:0]  operand,
   input  shift_kind_e   kind,
   input  logic [AW-1:0] amt,
   input  logic          carry_in,
   output logic          shift_carry
);

   logic [AW-1:0] idx;
   logic          amt_zero;

   // W is a power of two, so W - amt wraps to the two's complement of amt
   assign idx      = (kind == SK_LSL) ? (~amt + 1'b1) : (amt - 1'b1);
   assign amt_zero = (amt == '0);

   always_comb begin
      if (!amt_zero) begin
         shift_carry = operand[idx];
      end else begin
         unique case (kind)
            SK_LSL:         shift_carry = carry_in;
            SK_LSR, SK_ASR: shift_carry = operand[W-1];
            SK_ROR:         shift_carry = operand[0];
            default:        shift_carry = carry_in;
         endcase
      end
   end

endmodule

// File: rtl/bshift_imm.sv
module bshift_imm
   import bshift_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit LOG_STAGES = 1'b1,
   localparam int AMT_W     = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] operand,
   input  logic [1:0]        shift_kind,
   input  logic [AMT_W-1:0]  shift_amt,
   input  logic              carry_in,
   input  logic              flag_en,
   output logic [DATA_W-1:0] result,
   output logic              carry_out,
   output logic              carry_wr
);

   initial begin
      if (DATA_W < 8 || (1 << AMT_W) != DATA_W)
         $error("bshift_imm: DATA_W must be a power of two of at least 8");
   end

   shift_kind_e       kind;
   logic              amt_zero;
   logic [DATA_W-1:0] op_rev;
   logic [DATA_W-1:0] fun_hi;
   logic [DATA_W-1:0] fun_lo;
   logic [DATA_W-1:0] fun_out;
   logic [DATA_W-1:0] fun_rev;
   logic [DATA_W-1:0] moved;
   logic [DATA_W-1:0] special;
   logic              shift_carry;

   assign kind     = shift_kind_e'(shift_kind);
   assign amt_zero = (shift_amt == '0);

   // Left shifts reuse the right funnel on the bit-reversed word
   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_rev
         assign op_rev[b]  = operand[DATA_W-1-b];
         assign fun_rev[b] = fun_out[DATA_W-1-b];
      end
   endgenerate

   always_comb begin
      unique case (kind)
         SK_ROR:  fun_hi = operand;
         SK_ASR:  fun_hi = {DATA_W{operand[DATA_W-1]}};
         default: fun_hi = '0;
      endcase
   end

   assign fun_lo = (kind == SK_LSL) ? op_rev : operand;

   bshift_funnel #(
      .W          (DATA_W),
      .LOG_STAGES (LOG_STAGES)
   ) u_funnel (
      .hi   (fun_hi),
      .lo   (fun_lo),
      .amt  (shift_amt),
      .dout (fun_out)
   );

   assign moved = (kind == SK_LSL) ? fun_rev : fun_out;

   always_comb begin
      unique case (kind)
         SK_LSL:  special = operand;
         SK_LSR:  special = '0;
         SK_ASR:  special = {DATA_W{operand[DATA_W-1]}};
         SK_ROR:  special = {carry_in, operand[DATA_W-1:1]};
         default: special = operand;
      endcase
   end

   assign result = amt_zero ? special : moved;

   bshift_carry #(
      .W (DATA_W)
   ) u_carry (
      .operand     (operand),
      .kind        (kind),
      .amt         (shift_amt),
      .carry_in    (carry_in),
      .shift_carry (shift_carry)
   );

   assign carry_out = flag_en ? shift_carry : carry_in;
   assign carry_wr  = flag_en;

endmodule

// File: rtl/bshift_imm_chk.sv
module bshift_imm_chk #(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input logic [DATA_W-1:0] operand,
   input logic [1:0]        shift_kind,
   input logic [AMT_W-1:0]  shift_amt,
   input logic              carry_in,
   input logic              flag_en,
   input logic [DATA_W-1:0] result,
   input logic              carry_out,
   input logic              carry_wr
);

   always_comb begin
      if (!flag_en) begin
         a_r9_carry_hold : assert (carry_out == carry_in && !carry_wr)
            else $error("R9 carry not held with flags off");
      end
      if (flag_en) begin
         a_r10_strobe : assert (carry_wr)
            else $error("R10 strobe low with flags on");
      end
      if (shift_kind == 2'd0 && shift_amt == '0) begin
         a_r2_lsl0_pass : assert (result == operand && carry_out == carry_in)
            else $error("R2 zero left shift altered data or carry");
      end
      if (shift_kind == 2'd1 && shift_amt == '0) begin
         a_r4_lsr0_zero : assert (result == '0)
            else $error("R4 full logical shift not zero");
      end
      if (shift_kind == 2'd2 && shift_amt == '0) begin
         a_r6_asr0_fill : assert (result == {DATA_W{operand[DATA_W-1]}})
            else $error("R6 full arithmetic shift not sign fill");
      end
      if (shift_kind == 2'd3 && shift_amt == '0) begin
         a_r8_rrx : assert (result == {carry_in, operand[DATA_W-1:1]})
            else $error("R8 rotate through carry wrong");
      end
   end

endmodule

bind bshift_imm bshift_imm_chk #(.DATA_W(DATA_W)) u_chk (
   .operand    (operand),
   .shift_kind (shift_kind),
   .shift_amt  (shift_amt),
   .carry_in   (carry_in),
   .flag_en    (flag_en),
   .result     (result),
   .carry_out  (carry_out),
   .carry_wr   (carry_wr)
);

// File: tb/bshift_imm_bench.sv
`timescale 1ns/1ps
module bshift_imm_bench;

   logic        clk = 1'b0;
   logic [31:0] operand;
   logic [1:0]  shift_kind;
   logic [4:0]  shift_amt;
   logic        carry_in;
   logic        flag_en;
   logic [31:0] result;
   logic        carry_out;
   logic        carry_wr;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   bshift_imm u_bshift_imm (
      .operand    (operand),
      .shift_kind (shift_kind),
      .shift_amt  (shift_amt),
      .carry_in   (carry_in),
      .flag_en    (flag_en),
      .result     (result),
      .carry_out  (carry_out),
      .carry_wr   (carry_wr)
   );

   function automatic logic [31:0] ref_result(logic [31:0] x, logic [1:0] k,
                                              logic [4:0] n, logic ci);
      int s = int'(n);
      logic [63:0] w;
      case (k)
         2'd0: return (s == 0) ? x : (x << s);
         2'd1: return (s == 0) ? 32'd0 : (x >> s);
         2'd2: begin
            if (s == 0) return {32{x[31]}};
            w = {{32{x[31]}}, x} >> s;
            return w[31:0];
         end
         default: begin
            if (s == 0) return {ci, x[31:1]};
            return (x >> s) | (x << (32 - s));
         end
      endcase
   endfunction

   function automatic logic ref_carry(logic [31:0] x, logic [1:0] k,
                                      logic [4:0] n, logic ci, logic fe);
      int s = int'(n);
      if (!fe) return ci;
      if (s == 0) begin
         case (k)
            2'd0:    return ci;
            2'd3:    return x[0];
            default: return x[31];
         endcase
      end
      if (k == 2'd0) return x[32 - s];
      return x[s - 1];
   endfunction

   function automatic string tag_of(logic [1:0] k, logic [4:0] n);
      case (k)
         2'd0:    return (n == 0) ? "R2" : "R1";
         2'd1:    return (n == 0) ? "R4" : "R3";
         2'd2:    return (n == 0) ? "R6" : "R5";
         default: return (n == 0) ? "R8" : "R7";
      endcase
   endfunction

   task automatic apply(logic [31:0] x, logic [1:0] k, logic [4:0] n,
                        logic ci, logic fe);
      logic [31:0] er;
      logic        ec;
      string       t;
      @(negedge clk);
      operand = x; shift_kind = k; shift_amt = n; carry_in = ci; flag_en = fe;
      #2;
      er = ref_result(x, k, n, ci);
      ec = ref_carry(x, k, n, ci, fe);
      t  = fe ? tag_of(k, n) : "R9";
      vectors++;
      if (result !== er) begin
         fails++;
         $display("FAIL %s result k=%0d n=%0d x=%h ci=%0b: got %h exp %h",
                  t, k, n, x, ci, result, er);
      end
      if (carry_out !== ec) begin
         fails++;
         $display("FAIL %s carry k=%0d n=%0d x=%h ci=%0b fe=%0b: got %0b exp %0b",
                  t, k, n, x, ci, fe, carry_out, ec);
      end
      if (carry_wr !== fe) begin
         fails++;
         $display("FAIL %s strobe: got %0b exp %0b", fe ? "R10" : "R9", carry_wr, fe);
      end
   endtask

   initial begin
      logic [31:0] pats [6];
      int unsigned seed;
      pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
      pats[2] = 32'h8000_0001; pats[3] = 32'h7FFF_FFFE;
      pats[4] = 32'hA5A5_5A5A; pats[5] = 32'h1234_5678;
      seed = 32'd1729;
      void'($urandom(seed));

      // R2 R9: a quiet starting state, zero left shift with flags off
      apply(32'hDEAD_BEEF, 2'd0, 5'd0, 1'b1, 1'b0);

      // R1..R8 exhaustive sweep of kind and amount with directed words
      for (int k = 0; k < 4; k++)
         for (int n = 0; n < 32; n++)
            for (int p = 0; p < 6; p++)
               for (int c = 0; c < 2; c++)
                  apply(pats[p], 2'(k), 5'(n), 1'(c), 1'b1);

      // R8 with R9/R10: rotate through carry, both enables and carry values
      for (int c = 0; c < 2; c++)
         for (int f = 0; f < 2; f++) begin
            apply(32'h0000_0001, 2'd3, 5'd0, 1'(c), 1'(f));
            apply(32'hFFFF_FFFE, 2'd3, 5'd0, 1'(c), 1'(f));
         end

      // R1..R10 random words, every kind and amount, random carry and enable
      for (int i = 0; i < 4000; i++)
         apply($urandom, 2'($urandom), 5'($urandom), 1'($urandom), 1'($urandom));

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got hang exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule